// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Block

This block holds the inter-processor interrupt state of one core. Other cores, or the core itself, raise interrupt reasons in a 32-bit pending vector. They do it either through a write-only set register on the local bus or through a dedicated remote-set input driven by the cross-core fabric. The owning core reads the pending vector and then acknowledges the reasons it handled by writing the same value to a write-only clear register. A 32-bit enable register masks the reasons. A single level interrupt line goes to the core whenever an enabled reason is pending.

The block also contains a mailbox of four 64-bit words. A boot core places the start address, stack pointer, global pointer and one spare argument there for a parked core. The parked core treats the low 32 bits of word 0 as its launch flag: any nonzero value there starts it, and writing zero cancels a launch. That flag is also brought out as a separate output, so a parked core can watch it without a bus read.

All registers sit in a 256-byte window and are reached with 64-bit-aligned accesses. The 32-bit registers use the low data lane.

Top module: `ipi_regblk`

## Requirements
- R1: After reset, the pending vector, the enable mask and all four mailbox words read as zero, and both `irq` and `launch_req` are low.
- R2: A read of the pending vector (offset 0x00) returns the pending bits and changes no state, so two reads in a row return the same value.
- R3: A write to the clear register (offset 0x18) clears exactly the pending bits that are 1 in the strobe-qualified write data and leaves the others unchanged.
- R4: A write to the set register (offset 0x10) ORs the strobe-qualified write data into the pending vector.
- R5: When `ipi_set_valid` is high, `ipi_set_bits` is ORed into the pending vector at the next clock edge. If a remote set and a bus clear hit the same bit in the same cycle, the bit ends up set.
- R6: The enable mask (offset 0x08) is read/write. Only the bytes whose `bus_wstrb` bit is 1 are updated.
- R7: `irq` is high exactly one cycle after the pending vector ANDed with the enable mask is nonzero. With an all-zero mask, `irq` stays low.
- R8: The mailbox words 0 to 3 sit at offsets 0x20, 0x28, 0x30 and 0x38 and read back exactly what was written with all eight strobes set.
- R9: A mailbox write updates only the bytes whose strobe bit is 1. A 32-bit write with strobes 0x0F or 0xF0 changes only the low or the high half of the word.
- R10: `launch_req` is high exactly when bits 31:0 of mailbox word 0 are nonzero. A nonzero upper half alone does not raise it.
- R11: The set and clear registers read as zero. Offsets above 0x38 and accesses whose address bits 2:0 are nonzero read as zero, and writes to them have no effect. `bus_rdata` is zero while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read enable; data is returned in the same cycle |
| bus_addr | input | 8 | Byte offset inside the 256-byte window |
| bus_wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| bus_wstrb | input | 8 | Byte write enables |
| bus_rdata | output | 64 | Read data |
| ipi_set_valid | input | 1 | Remote set request from the interrupt fabric |
| ipi_set_bits | input | 32 | Reasons to raise with a remote set |
| irq | output | 1 | Level interrupt to the owning core |
| launch_req | output | 1 | Low half of mailbox word 0 is nonzero |

## Verification
The assertions watch several things on every cycle. A remote set always lands even when a clear hits the same bit. A full-width clear or set leaves the pending vector in the state it names. Reads never disturb the pending vector. An empty mask keeps `irq` low. `launch_req` only rises after a bus write. Strobe-masked partial writes, the exact one-cycle lag of `irq` behind an enable change, the cases where the upper half of word 0 must not raise `launch_req`, and the silence of unmapped and misaligned offsets can only be shown by the bench's directed scenarios.

// File: rtl/ipi_regblk_pkg.sv
package ipi_regblk_pkg;
    // Slot = byte offset / 8; 32-bit registers live in the low lane.
    localparam int SLOT_STATUS = 0;
    localparam int SLOT_ENABLE = 1;
    localparam int SLOT_SET    = 2;
    localparam int SLOT_CLEAR  = 3;
    localparam int SLOT_MBOX0  = 4;
    localparam int LANE_BYTES  = 8;
    localparam int LANE_LSB    = 3;
endpackage

// File: rtl/ipi_bus_decode.sv
module ipi_bus_decode
    import ipi_regblk_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 64,
    parameter int MBOX_WORDS = 4
) (
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W/8-1:0]       bus_wstrb,
    output logic                      wr_enable,
    output logic                      wr_set,
    output logic                      wr_clear,
    output logic [MBOX_WORDS-1:0]     wr_mbox,
    output logic                      rd_hit,
    output logic [ADDR_W-LANE_LSB-1:0] slot,
    output logic [DATA_W-1:0]         wmask
);
    localparam int SLOT_W  = ADDR_W - LANE_LSB;
    localparam int N_BYTES = DATA_W / 8;
    localparam int SLOT_END = SLOT_MBOX0 + MBOX_WORDS;

    logic aligned;
    logic mapped;
    logic wr_ok;

    assign slot    = bus_addr[ADDR_W-1:LANE_LSB];
    assign aligned = (bus_addr[LANE_LSB-1:0] == '0);
    assign mapped  = aligned && (slot < SLOT_W'(SLOT_END));
    assign wr_ok   = bus_wr && mapped;
    assign rd_hit  = bus_rd && mapped;

    assign wr_enable = wr_ok && (slot == SLOT_W'(SLOT_ENABLE));
    assign wr_set    = wr_ok && (slot == SLOT_W'(SLOT_SET));
    assign wr_clear  = wr_ok && (slot == SLOT_W'(SLOT_CLEAR));

    for (genvar w = 0; w < MBOX_WORDS; w++) begin : g_mbox_sel
        assign wr_mbox[w] = wr_ok && (slot == SLOT_W'(SLOT_MBOX0 + w));
    end

    for (genvar b = 0; b < N_BYTES; b++) begin : g_mask
        assign wmask[b*8 +: 8] = {8{bus_wstrb[b]}};
    end
endmodule

// File: rtl/ipi_status_unit.sv
module ipi_status_unit #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_enable,
    input  logic             wr_set,
    input  logic             wr_clear,
    input  logic [REG_W-1:0] wmask,
    input  logic [REG_W-1:0] wdata,
    input  logic             rmt_set_valid,
    input  logic [REG_W-1:0] rmt_set_bits,
    output logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] enable_q,
    output logic             irq_q
);
    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] enable;
        logic             irq;
    } state_t;

    state_t           st_d, st_q;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;

    always_comb begin
        st_d    = st_q;
        set_vec = (wr_set ? (wdata & wmask) : '0)
                | (rmt_set_valid ? rmt_set_bits : '0);
        clr_vec = wr_clear ? (wdata & wmask) : '0;
        // set is applied after clear, so a simultaneous set wins
        st_d.status = (st_q.status & ~clr_vec) | set_vec;
        if (wr_enable) begin
            st_d.enable = (st_q.enable & ~wmask) | (wdata & wmask);
        end
        st_d.irq = |(st_q.status & st_q.enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = st_q.status;
    assign enable_q = st_q.enable;
    assign irq_q    = st_q.irq;
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
    parameter int DATA_W     = 64,
    parameter int MBOX_WORDS = 4,
    parameter int LAUNCH_W   = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [MBOX_WORDS-1:0]        wr_sel,
    input  logic [DATA_W-1:0]            wmask,
    input  logic [DATA_W-1:0]            wdata,
    output logic [MBOX_WORDS*DATA_W-1:0] words_q,
    output logic                         launch
);
    for (genvar w = 0; w < MBOX_WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (wr_sel[w]) begin
                word_d = (word_q & ~wmask) | (wdata & wmask);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign words_q[w*DATA_W +: DATA_W] = word_q;
    end

    // launch flag is the 32-bit view of word 0
    assign launch = |words_q[LAUNCH_W-1:0];
endmodule

// File: rtl/ipi_regblk.sv
module ipi_regblk
    import ipi_regblk_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 64,
    parameter int REG_W      = 32,
    parameter int MBOX_WORDS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W/8-1:0] bus_wstrb,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                ipi_set_valid,
    input  logic [REG_W-1:0]    ipi_set_bits,
    output logic                irq,
    output logic                launch_req
);
    localparam int SLOT_W = ADDR_W - LANE_LSB;

    logic                         wr_enable, wr_set, wr_clear, rd_hit;
    logic [MBOX_WORDS-1:0]        wr_mbox;
    logic [SLOT_W-1:0]            slot;
    logic [DATA_W-1:0]            wmask;
    logic [REG_W-1:0]             status_vec;
    logic [REG_W-1:0]             enable_vec;
    logic [MBOX_WORDS*DATA_W-1:0] mbox_flat;

    ipi_bus_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)
    ) u_dec (
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wstrb(bus_wstrb), .wr_enable(wr_enable), .wr_set(wr_set),
        .wr_clear(wr_clear), .wr_mbox(wr_mbox), .rd_hit(rd_hit),
        .slot(slot), .wmask(wmask)
    );

    ipi_status_unit #(.REG_W(REG_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .wr_enable(wr_enable), .wr_set(wr_set),
        .wr_clear(wr_clear), .wmask(wmask[REG_W-1:0]),
        .wdata(bus_wdata[REG_W-1:0]), .rmt_set_valid(ipi_set_valid),
        .rmt_set_bits(ipi_set_bits), .status_q(status_vec),
        .enable_q(enable_vec), .irq_q(irq)
    );

    ipi_mailbox #(
        .DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS), .LAUNCH_W(REG_W)
    ) u_mbox (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_mbox), .wmask(wmask),
        .wdata(bus_wdata), .words_q(mbox_flat), .launch(launch_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            if (slot == SLOT_W'(SLOT_STATUS)) begin
                bus_rdata = DATA_W'(status_vec);
            end else if (slot == SLOT_W'(SLOT_ENABLE)) begin
                bus_rdata = DATA_W'(enable_vec);
            end
            for (int w = 0; w < MBOX_WORDS; w++) begin
                if (slot == SLOT_W'(SLOT_MBOX0 + w)) begin
                    bus_rdata = mbox_flat[w*DATA_W +: DATA_W];
                end
            end
        end
    end
endmodule

// File: rtl/ipi_regblk_chk.sv
module ipi_regblk_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64,
    parameter int REG_W  = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W/8-1:0] bus_wstrb,
    input logic                ipi_set_valid,
    input logic [REG_W-1:0]    ipi_set_bits,
    input logic                irq,
    input logic                launch_req,
    input logic [REG_W-1:0]    status_vec,
    input logic [REG_W-1:0]    enable_vec
);
    localparam int RB = REG_W / 8;

    logic full_lo;
    assign full_lo = (bus_wstrb[RB-1:0] == {RB{1'b1}});

    a_r5_remote_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_set_valid |=> ((status_vec & $past(ipi_set_bits)) == $past(ipi_set_bits)));

    a_r3_clear_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8'h18) && full_lo && !ipi_set_valid)
        |=> ((status_vec & $past(bus_wdata[REG_W-1:0])) == '0));

    a_r4_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8'h10) && full_lo)
        |=> ((status_vec & $past(bus_wdata[REG_W-1:0])) == $past(bus_wdata[REG_W-1:0])));

    a_r2_read_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !ipi_set_valid) |=> $stable(status_vec));

    a_r7_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_vec == '0) |=> !irq);

    a_r7_pending_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_vec & enable_vec) != '0) |=> irq);

    a_r10_launch_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(launch_req) |-> $past(bus_wr));
endmodule

bind ipi_regblk ipi_regblk_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .ipi_set_valid(ipi_set_valid), .ipi_set_bits(ipi_set_bits),
    .irq(irq), .launch_req(launch_req), .status_vec(status_vec),
    .enable_vec(enable_vec)
);

// File: tb/ipi_regblk_tb_top.sv
module ipi_regblk_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [7:0]  bus_wstrb = '0;
    logic [63:0] bus_rdata;
    logic        ipi_set_valid = 1'b0;
    logic [31:0] ipi_set_bits = '0;
    logic        irq;
    logic        launch_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    ipi_regblk dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
        .bus_rdata(bus_rdata), .ipi_set_valid(ipi_set_valid),
        .ipi_set_bits(ipi_set_bits), .irq(irq), .launch_req(launch_req)
    );

    // {op(2), req(4), addr(8), data(64), strb(8)}; op 1 = write, 2 = read+compare
    localparam int NV = 27;
    localparam logic [85:0] VEC [NV] = '{
        {2'd1, 4'd6,  8'h08, 64'h0000_0000_FFFF_FFFF, 8'h0F},  // R6
        {2'd2, 4'd6,  8'h08, 64'h0000_0000_FFFF_FFFF, 8'h00},  // R6
        {2'd1, 4'd6,  8'h08, 64'h0000_0000_0000_0000, 8'h02},  // R6 byte1 only
        {2'd2, 4'd6,  8'h08, 64'h0000_0000_FFFF_00FF, 8'h00},  // R6
        {2'd1, 4'd4,  8'h10, 64'h0000_0000_0000_00A5, 8'h0F},  // R4
        {2'd2, 4'd4,  8'h00, 64'h0000_0000_0000_00A5, 8'h00},  // R4
        {2'd2, 4'd2,  8'h00, 64'h0000_0000_0000_00A5, 8'h00},  // R2 second read
        {2'd1, 4'd3,  8'h18, 64'h0000_0000_0000_0005, 8'h0F},  // R3
        {2'd2, 4'd3,  8'h00, 64'h0000_0000_0000_00A0, 8'h00},  // R3
        {2'd1, 4'd4,  8'h10, 64'h0000_0000_0001_0000, 8'h0F},  // R4 OR in
        {2'd2, 4'd4,  8'h00, 64'h0000_0000_0001_00A0, 8'h00},  // R4
        {2'd1, 4'd8,  8'h20, 64'h1111_2222_3333_4444, 8'hFF},  // R8
        {2'd1, 4'd8,  8'h28, 64'h5555_6666_7777_8888, 8'hFF},  // R8
        {2'd1, 4'd8,  8'h30, 64'h9999_AAAA_BBBB_CCCC, 8'hFF},  // R8
        {2'd1, 4'd8,  8'h38, 64'hDDDD_EEEE_FFFF_0001, 8'hFF},  // R8
        {2'd2, 4'd8,  8'h20, 64'h1111_2222_3333_4444, 8'h00},  // R8
        {2'd2, 4'd8,  8'h38, 64'hDDDD_EEEE_FFFF_0001, 8'h00},  // R8
        {2'd1, 4'd9,  8'h28, 64'h0000_0000_DEAD_BEEF, 8'h0F},  // R9 low half
        {2'd2, 4'd9,  8'h28, 64'h5555_6666_DEAD_BEEF, 8'h00},  // R9
        {2'd1, 4'd9,  8'h30, 64'hCAFE_F00D_0000_0000, 8'hF0},  // R9 high half
        {2'd2, 4'd9,  8'h30, 64'hCAFE_F00D_BBBB_CCCC, 8'h00},  // R9
        {2'd2, 4'd11, 8'h10, 64'h0000_0000_0000_0000, 8'h00},  // R11 set reads 0
        {2'd2, 4'd11, 8'h18, 64'h0000_0000_0000_0000, 8'h00},  // R11 clear reads 0
        {2'd1, 4'd11, 8'h0C, 64'h0000_0000_0000_0000, 8'h0F},  // R11 misaligned
        {2'd2, 4'd11, 8'h08, 64'h0000_0000_FFFF_00FF, 8'h00},  // R11 untouched
        {2'd1, 4'd11, 8'h48, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF},  // R11 unmapped
        {2'd2, 4'd11, 8'h48, 64'h0000_0000_0000_0000, 8'h00}   // R11
    };

    task automatic check(input logic [63:0] act, input logic [63:0] exp,
                         input int req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [63:0] d,
                             input logic [7:0] s);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_wr = 1'b0; bus_wstrb = '0;
    endtask

    task automatic bus_read_check(input logic [7:0] a, input logic [63:0] exp,
                                  input int req, input string what);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        check(bus_rdata, exp, req, what);
        bus_rd = 1'b0;
    endtask

    task automatic reset_checks();
        check(64'(irq), 64'd0, 1, "irq after reset");           // R1
        check(64'(launch_req), 64'd0, 1, "launch after reset"); // R1
        bus_read_check(8'h00, 64'd0, 1, "status after reset");
        bus_read_check(8'h08, 64'd0, 1, "enable after reset");
        for (int w = 0; w < 4; w++) begin
            bus_read_check(8'(8'h20 + 8 * w), 64'd0, 1, "mailbox after reset");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_checks();

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][85:84] == 2'd1) begin
                bus_write(VEC[i][79:72], VEC[i][71:8], VEC[i][7:0]);
            end else begin
                bus_read_check(VEC[i][79:72], VEC[i][71:8], int'(VEC[i][83:80]), "table");
            end
        end

        // R7: mask gating and one-cycle latency
        bus_write(8'h18, 64'hFFFF_FFFF, 8'h0F);
        bus_write(8'h08, 64'h0, 8'h0F);
        bus_write(8'h10, 64'h8, 8'h0F);
        @(negedge clk); #1;
        check(64'(irq), 64'd0, 7, "irq masked");
        bus_write(8'h08, 64'h8, 8'h0F);
        #1;
        check(64'(irq), 64'd0, 7, "irq one cycle later, not yet");
        @(posedge clk); #1;
        check(64'(irq), 64'd1, 7, "irq after latency");

        // R5: remote set vs bus clear on the same bit
        @(negedge clk);
        ipi_set_valid = 1'b1; ipi_set_bits = 32'h108;
        bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 64'h108; bus_wstrb = 8'h0F;
        @(negedge clk);
        ipi_set_valid = 1'b0; bus_wr = 1'b0; bus_wstrb = '0;
        bus_read_check(8'h00, 64'h108, 5, "set wins over clear");
        @(negedge clk);
        ipi_set_valid = 1'b1; ipi_set_bits = 32'h200;
        bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 64'h100; bus_wstrb = 8'h0F;
        @(negedge clk);
        ipi_set_valid = 1'b0; bus_wr = 1'b0; bus_wstrb = '0;
        bus_read_check(8'h00, 64'h208, 5, "remote set with other clear");

        // R10: launch flag is the low half of word 0
        bus_write(8'h20, 64'h0, 8'hFF);
        check(64'(launch_req), 64'd0, 10, "word0 zero");
        bus_write(8'h20, 64'h0000_0001_0000_0000, 8'hFF);
        check(64'(launch_req), 64'd0, 10, "upper half only");
        bus_write(8'h20, 64'h0000_0000_0000_0040, 8'h0F);
        check(64'(launch_req), 64'd1, 10, "low half nonzero");
        bus_read_check(8'h20, 64'h0000_0001_0000_0040, 10, "word0 value");
        bus_rd = 1'b0; #1;
        check(bus_rdata, 64'd0, 11, "rdata idle");  // R11

        // R1: reset in the middle of activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        reset_checks();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule